// File: doc/BRIEF.md
# Field Motion Difference Accumulator

This block measures how much the picture changes from one field to the next. Two 8-bit luminance streams arrive side by side. One carries the current field and the other carries the field before it, read back from a field store. A qualifier marks active video. For every qualified pixel the block takes the upper nibble of each sample, forms the magnitude of their difference and adds it to a running per-field total. A control loop can read the per-field totals to find the phase of a film cadence, because fields that repeat a film frame give very small totals.

During field blanking a field strobe rises. On that edge the upper sixteen bits of the total move into a result register, and the total restarts from zero for the next field. The processor reads the result register. A one-cycle read strobe clears it, so each field's figure is consumed once. The total saturates at its full-scale value and never wraps. Widths, the number of compared bits and the saturate-or-wrap choice are parameters.

Top module: `fld_motion_acc`

## Requirements
- R1: After reset the result `rd_data` reads zero and the running total is zero.
- R2: A pixel contributes nothing when `vid_act` is low at the clock edge that samples it.
- R3: Only the top 4 bits (bits 7:4) of each luminance sample take part. Differences confined to bits 3:0 add nothing.
- R4: Each qualified pixel adds |luma_now[7:4] − luma_old[7:4]|, the same whichever stream holds the larger value.
- R5: On the clock edge where `fld_stb` is high and was low in the previous cycle, `rd_data` takes bits 23:8 of the 24-bit total. Pixels sampled at least two edges before that edge are included.
- R6: On that same edge the total is set to zero, so the next result covers only pixels sampled after the edge.
- R7: Holding `fld_stb` high causes no further transfer. Only a low-to-high change transfers.
- R8: A read pulse (`rd_stb` high for one edge) makes `rd_data` zero from the next cycle on.
- R9: When a read and a transfer meet on the same edge, the transferred value is kept and the read has no effect.
- R10: The total saturates at all ones instead of wrapping, so the reported field of a saturated total is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_act | input | 1 | High while the pixel pair is active video |
| luma_now | input | 8 | Luminance of the current field |
| luma_old | input | 8 | Luminance of the previous field at the same position |
| fld_stb | input | 1 | Field strobe; its rising edge transfers and restarts |
| rd_stb | input | 1 | Read pulse from the processor port; clears the result |
| rd_data | output | 16 | Result register: upper 16 bits of the last field total |

## Verification
A pixel pair passes one register stage for its difference and a second for the total. A pixel sampled at edge k is therefore in the total from edge k+2. The bench always leaves at least two idle edges before it raises the field strobe. The transferred value and the clear after a read both appear one edge after the strobe or read. The bench drives inputs and samples `rd_data` on falling edges, so every comparison falls half a period after the edge that must produce the value. A second instance with a 12-bit total reaches saturation within a few hundred pixels.

// File: rtl/fma_pkg.sv
`timescale 1ns/1ps
package fma_pkg;
   localparam int unsigned FMA_PIX_W    = 8;
   localparam int unsigned FMA_CMP_BITS = 4;
   localparam int unsigned FMA_ACC_W    = 24;
   localparam int unsigned FMA_RES_W    = 16;

   // largest difference that a compare of n bits can produce
   function automatic int unsigned fma_max_step(input int unsigned n);
      return (1 << n) - 1;
   endfunction
endpackage

// File: rtl/fma_diff.sv
`timescale 1ns/1ps
module fma_diff #(
   parameter int unsigned PIX_W    = 8,
   parameter int unsigned CMP_BITS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vid_act,
   input  logic [PIX_W-1:0]    luma_now,
   input  logic [PIX_W-1:0]    luma_old,
   output logic                d_vld,
   output logic [CMP_BITS-1:0] d_mag
);
   localparam int unsigned TOP = PIX_W - 1;

   logic [CMP_BITS-1:0] nib_now, nib_old, mag_c;

   assign nib_now = luma_now[TOP -: CMP_BITS];
   assign nib_old = luma_old[TOP -: CMP_BITS];
   assign mag_c   = (nib_now >= nib_old) ? (nib_now - nib_old) : (nib_old - nib_now);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_vld <= 1'b0;
         d_mag <= '0;
      end else begin
         d_vld <= vid_act;
         d_mag <= vid_act ? mag_c : '0;
      end
   end

   // R2: blanked pixels never reach the adder
   assert_blank_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !vid_act |=> (!d_vld && d_mag == '0));

   // R3: equal upper bits give a zero step whatever the low bits are
   assert_low_bits_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vid_act && luma_now[TOP -: CMP_BITS] == luma_old[TOP -: CMP_BITS]) |=> d_mag == '0);
endmodule

// File: rtl/fma_edge.sv
`timescale 1ns/1ps
module fma_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_in,
   output logic rise
);
   logic stb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q <= 1'b0;
      else        stb_q <= stb_in;
   end

   assign rise = stb_in & ~stb_q;

   // R7: a held strobe yields one transfer only
   assert_single_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/fma_accum.sv
`timescale 1ns/1ps
module fma_accum #(
   parameter int unsigned STEP_W   = 4,
   parameter int unsigned ACC_W    = 24,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              add_vld,
   input  logic [STEP_W-1:0] add_val,
   output logic [ACC_W-1:0]  acc
);
   localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

   logic [ACC_W:0]   sum;
   logic [ACC_W-1:0] nxt;

   assign sum = {1'b0, acc} + {{(ACC_W + 1 - STEP_W){1'b0}}, add_val};

   generate
      if (SATURATE) begin : g_sat
         assign nxt = sum[ACC_W] ? FULL : sum[ACC_W-1:0];
      end else begin : g_wrap
         assign nxt = sum[ACC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (clear)   acc <= '0;
      else if (add_vld) acc <= nxt;
   end

   // R6: the strobe edge restarts the field total
   assert_restart_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> acc == '0);

   generate
      if (SATURATE) begin : g_sat_chk
         // R10: a full total stays full until the next restart
         assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (acc == FULL && !clear) |=> acc == FULL);
         // R10: without a restart the total never falls
         assert_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> acc >= $past(acc));
      end
   endgenerate
endmodule

// File: rtl/fma_result.sv
`timescale 1ns/1ps
module fma_result #(
   parameter int unsigned RES_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [RES_W-1:0] load_val,
   input  logic             rd,
   output logic [RES_W-1:0] res
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    res <= '0;
      else if (load) res <= load_val;
      else if (rd)   res <= '0;
   end

   // R8: a lone read empties the register
   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !load) |=> res == '0);

   // R9: a transfer lands even with a read on the same edge
   assert_transfer_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> res == $past(load_val));

   // R5: between events the register holds
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !rd) |=> $stable(res));
endmodule

// File: rtl/fld_motion_acc.sv
`timescale 1ns/1ps
module fld_motion_acc #(
   parameter int unsigned PIX_W    = fma_pkg::FMA_PIX_W,
   parameter int unsigned CMP_BITS = fma_pkg::FMA_CMP_BITS,
   parameter int unsigned ACC_W    = fma_pkg::FMA_ACC_W,
   parameter int unsigned RES_W    = fma_pkg::FMA_RES_W,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vid_act,
   input  logic [PIX_W-1:0] luma_now,
   input  logic [PIX_W-1:0] luma_old,
   input  logic             fld_stb,
   input  logic             rd_stb,
   output logic [RES_W-1:0] rd_data
);
   localparam int unsigned MAX_STEP = fma_pkg::fma_max_step(CMP_BITS);

   initial begin
      assert (CMP_BITS >= 1 && CMP_BITS <= PIX_W)
         else $error("CMP_BITS must lie in 1..PIX_W");
      assert (RES_W >= 1 && RES_W <= ACC_W)
         else $error("RES_W must lie in 1..ACC_W");
      assert (ACC_W > CMP_BITS)
         else $error("ACC_W must exceed CMP_BITS");
   end

   logic                step_vld;
   logic [CMP_BITS-1:0] step_mag;
   logic                stb_rise;
   logic [ACC_W-1:0]    total;
   logic [RES_W-1:0]    total_hi;

   fma_diff #(.PIX_W(PIX_W), .CMP_BITS(CMP_BITS)) u_diff (
      .clk(clk), .rst_n(rst_n), .vid_act(vid_act),
      .luma_now(luma_now), .luma_old(luma_old),
      .d_vld(step_vld), .d_mag(step_mag)
   );

   fma_edge u_edge (
      .clk(clk), .rst_n(rst_n), .stb_in(fld_stb), .rise(stb_rise)
   );

   fma_accum #(.STEP_W(CMP_BITS), .ACC_W(ACC_W), .SATURATE(SATURATE)) u_acc (
      .clk(clk), .rst_n(rst_n), .clear(stb_rise),
      .add_vld(step_vld), .add_val(step_mag), .acc(total)
   );

   assign total_hi = total[ACC_W-1 -: RES_W];

   fma_result #(.RES_W(RES_W)) u_res (
      .clk(clk), .rst_n(rst_n), .load(stb_rise), .load_val(total_hi),
      .rd(rd_stb), .res(rd_data)
   );

   // R4: one pixel never adds more than the largest nibble difference
   assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb_rise && !(&total)) |=> (total - $past(total)) <= ACC_W'(MAX_STEP));

   // R1: reset leaves an empty result
   always_ff @(posedge clk) begin
      if (!rst_n) assert_reset_empty_R1: assert (rd_data == '0);
   end
endmodule

// File: tb/fld_motion_acc_test.sv
`timescale 1ns/1ps
module fld_motion_acc_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vid_act = 1'b0;
   logic [7:0] luma_now = '0;
   logic [7:0] luma_old = '0;
   logic       fld_stb = 1'b0;
   logic       rd_stb = 1'b0;
   logic [15:0] rd_data;
   logic [7:0]  rd_small;

   int checks = 0;
   int errors = 0;
   int sum    = 0;   // bench model of the running total
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   fld_motion_acc uut (
      .clk(clk), .rst_n(rst_n), .vid_act(vid_act), .luma_now(luma_now),
      .luma_old(luma_old), .fld_stb(fld_stb), .rd_stb(rd_stb), .rd_data(rd_data)
   );

   fld_motion_acc #(.ACC_W(12), .RES_W(8)) uut_sat (
      .clk(clk), .rst_n(rst_n), .vid_act(vid_act), .luma_now(luma_now),
      .luma_old(luma_old), .fld_stb(fld_stb), .rd_stb(rd_stb), .rd_data(rd_small)
   );

   function automatic int step(input int a, input int b);
      int x = a >> 4;
      int y = b >> 4;
      return (x > y) ? x - y : y - x;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pix(input int a, input int b, input bit v);
      @(negedge clk);
      luma_now = a[7:0]; luma_old = b[7:0]; vid_act = v;
      if (v) sum += step(a, b);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) pix(0, 0, 1'b0);
   endtask

   task automatic strobe();
      idle(2);
      @(negedge clk); fld_stb = 1'b1;
      @(negedge clk); fld_stb = 1'b0;
      sum = 0;
   endtask

   task automatic rd_pulse();
      @(negedge clk); rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 result after reset", rd_data, 0);
      check("R1 small result after reset", rd_small, 0);
      strobe();   // empty field: total was zero
      check("R1 empty total transfers zero", rd_data, 0);
   endtask

   task automatic t_mixed();
      int exp;
      for (int i = 0; i < 400; i++) pix((i * 37) & 255, (i * 91 + 13) & 255, 1'b1);
      exp = sum >> 8;
      strobe();
      check("R5 mixed field upper bytes", rd_data, exp);
      check("R5 nonzero pattern", int'(exp > 0), 1);
   endtask

   task automatic t_blank();
      for (int i = 0; i < 200; i++) pix(8'hF0, 8'h00, 1'b0);
      for (int i = 0; i < 20; i++)  pix(8'hF0, 8'h00, 1'b1);
      strobe();
      check("R2 blanked pixels ignored", rd_data, 1);
   endtask

   task automatic t_low_bits();
      for (int i = 0; i < 200; i++) pix(8'h0F, 8'h00, 1'b1);
      for (int i = 0; i < 200; i++) pix(8'hA7, 8'hA9, 1'b1);
      for (int i = 0; i < 20; i++)  pix(8'hF0, 8'h00, 1'b1);
      strobe();
      check("R3 low nibble ignored", rd_data, 1);
   endtask

   task automatic t_abs();
      for (int i = 0; i < 20; i++) pix(8'h00, 8'hF0, 1'b1);
      strobe();
      check("R4 old larger gives magnitude", rd_data, 1);
      for (int i = 0; i < 128; i++) pix(8'h20, 8'h60, 1'b1);
      for (int i = 0; i < 128; i++) pix(8'h60, 8'h20, 1'b1);
      strobe();
      check("R4 symmetric difference", rd_data, 4);
   endtask

   task automatic t_restart();
      for (int i = 0; i < 300; i++) pix(8'hFF, 8'h00, 1'b1);
      strobe();
      check("R6 first field", rd_data, 17);
      for (int i = 0; i < 40; i++) pix(8'h80, 8'h00, 1'b1);
      strobe();
      check("R6 second field alone", rd_data, 1);
   endtask

   task automatic t_held();
      for (int i = 0; i < 300; i++) pix(8'hFF, 8'h00, 1'b1);
      idle(2);
      @(negedge clk); fld_stb = 1'b1;
      sum = 0;
      for (int i = 0; i < 100; i++) pix(8'hF0, 8'h00, 1'b1);
      idle(2);
      check("R7 held strobe no second transfer", rd_data, 17);
      @(negedge clk); fld_stb = 1'b0;
      strobe();
      check("R7 next rise carries later pixels", rd_data, 5);
   endtask

   task automatic t_read();
      for (int i = 0; i < 300; i++) pix(8'hFF, 8'h00, 1'b1);
      strobe();
      check("R8 value before read", rd_data, 17);
      rd_pulse();
      check("R8 read clears", rd_data, 0);
      idle(3);
      check("R8 stays clear", rd_data, 0);
   endtask

   task automatic t_collide();
      for (int i = 0; i < 300; i++) pix(8'hFF, 8'h00, 1'b1);
      idle(2);
      @(negedge clk); fld_stb = 1'b1; rd_stb = 1'b1;
      @(negedge clk); fld_stb = 1'b0; rd_stb = 1'b0;
      sum = 0;
      check("R9 transfer beats read", rd_data, 17);
   endtask

   task automatic t_sat();
      for (int i = 0; i < 400; i++) pix(8'hF0, 8'h00, 1'b1);
      strobe();
      check("R10 small total saturates", rd_small, 255);
      check("R10 wide total unaffected", rd_data, 23);
      rd_pulse();
      for (int i = 0; i < 100; i++) pix(8'hF0, 8'h00, 1'b1);
      strobe();
      check("R10 restart after saturation", rd_small, 93);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mixed();
      t_blank();
      t_low_bits();
      t_abs();
      t_restart();
      t_held();
      t_read();
      t_collide();
      t_sat();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule